// File: doc/BRIEF.md
# Five-Channel Output Compare Bank

The compare bank watches a shared 16-bit free-running counter that lives outside the block. Five channels each hold a 16-bit compare value. When the counter reaches a channel's value, that channel's flag sets. Each channel also has an enable bit. The interrupt request is raised when any flag is set while its own enable is on.

The counter is not required to advance by one between samples. The block reads the counter only on cycles where the advance strobe is high. On each strobe it checks the whole span from the previous sample up to the new one. A compare value anywhere inside that span counts as reached, and this includes spans that wrap from 0xFFFF through 0x0000.

Software talks to the block through byte-wide register writes and combinational reads. A small state machine has two states:
- WAIT_ENABLE: no enable bit is set, so match scheduling is inactive.
- TRACK: at least one enable bit is set, so matching runs.

There are two transitions:
- ENABLE_ON: a mask write with a nonzero enable field, WAIT_ENABLE to TRACK.
- ENABLE_OFF: a mask write with an all-zero enable field, TRACK to WAIT_ENABLE.

Every write to a compare byte or to the mask restarts the match window at the counter value present during that write.

Top module: `compare_bank`

## Requirements
- R1: Reset sets every compare register to 0xFFFF, clears all enables and flags, drives irq low and enters WAIT_ENABLE.
- R2: Register addresses are:
  - Channel k (k = 0..4, channel 1 is k = 0): high byte at address 2k, low byte at address 2k+1.
  - Mask byte: address 10.
  - Flag byte: address 11.
  - Addresses 12 to 15 read as 0x00, and writes to them have no effect.
  - Reads are combinational from addr.
- R3: In both the mask byte and the flag byte, channel k sits at bit 7-k. Bits 2:0 read as zero and ignore writes. The flag_o port carries bits 7:3 of the flag byte, so flag_o[4] is channel 1.
- R4: In TRACK, on a cycle with cnt_adv high and no compare or mask write, a channel's flag sets when its compare value C satisfies 0 < (C - P) mod 2^16 <= (V - P) mod 2^16. Here P is the counter value at the previous advance (or at the last rebase) and V is cnt_val. The flag is visible on the next cycle.
- R5: A span that wraps from 0xFFFF to 0x0000 detects compare values on both sides of the wrap.
- R6: A flag sets once per counter pass through the compare value. After the flag is cleared, an advance whose span excludes the value, including an advance to the same counter value, leaves it clear.
- R7: Writing the flag byte clears each flag whose bit is 1 and leaves flags whose bit is 0 unchanged. A match in the same cycle wins over the clear.
- R8: In WAIT_ENABLE, no flag sets, whatever the counter does.
- R9: A write to any compare byte or to the mask sets P to cnt_val during that write and detects nothing in that cycle. A compare value equal to that counter value is therefore not flagged until the next pass.
- R10: irq is high exactly when some channel has both its flag and its enable set. Flags of disabled channels still set while in TRACK but do not raise irq.
- R11: While cnt_adv is low, changes on cnt_val neither set flags nor move P. A crossing made between strobes is caught at the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_val | input | 16 | Current value of the shared counter |
| cnt_adv | input | 1 | High on cycles where cnt_val holds a newly advanced value |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register byte address for reads and writes |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr |
| flag_o | output | 5 | Channel flags, bit 4 = channel 1 |
| irq | output | 1 | Combined interrupt request |

## Verification
The counter is driven through several kinds of advance, each aimed at a different detection error:
- Single-step advances that stop just short of a compare value and then land on it, which catch off-by-one window edges.
- Large forward jumps that cover two channels at once.
- A jump that wraps through zero.
- An advance to the same value, which must not re-flag.
- Counter changes with the strobe held low.

Writes that land in the same cycle as an advance separate rebase priority from detection. A flag clear that coincides with a match separates set-wins from clear-wins. Running with only one enable set, while other channels are crossed, separates flag setting from interrupt gating.

// File: rtl/cb_pkg.sv
package cb_pkg;

    // Match scheduling state of the compare bank.
    typedef enum logic [0:0] {
        ST_WAIT_ENABLE = 1'b0,
        ST_TRACK       = 1'b1
    } cb_state_e;

    // Decoded kind of a register write.
    typedef struct packed {
        logic cmp;
        logic mask;
        logic flag;
    } cb_wr_kind_t;

endpackage

// File: rtl/cb_regfile.sv
module cb_regfile
    import cb_pkg::*;
#(
    parameter int NUM_CH = 5,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  cb_wr_kind_t             wr_kind,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [DATA_W-1:0]       wdata,
    input  logic [NUM_CH-1:0]       ch_bits,
    output logic [NUM_CH*CNT_W-1:0] cmp_flat,
    output logic [NUM_CH-1:0]       en_vec
);
    localparam int BYTES  = CNT_W / DATA_W;
    localparam int NBYTES = NUM_CH * BYTES;

    logic [DATA_W-1:0] byte_q [NBYTES];

    // Compare bytes, stored high byte first per channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NBYTES; i++) begin
                byte_q[i] <= '1;
            end
        end else if (wr_kind.cmp) begin
            for (int i = 0; i < NBYTES; i++) begin
                if (addr == ADDR_W'(i)) begin
                    byte_q[i] <= wdata;
                end
            end
        end
    end

    // Enable bits, one per channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_vec <= '0;
        end else if (wr_kind.mask) begin
            en_vec <= ch_bits;
        end
    end

    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        for (genvar b = 0; b < BYTES; b++) begin : g_byte
            assign cmp_flat[k*CNT_W + (BYTES-1-b)*DATA_W +: DATA_W] = byte_q[k*BYTES + b];
        end
    end

endmodule

// File: rtl/cb_window.sv
module cb_window #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] prev_val,
    input  logic [CNT_W-1:0] now_val,
    input  logic [CNT_W-1:0] cmp_val,
    output logic             hit
);
    logic [CNT_W-1:0] dist_cmp;
    logic [CNT_W-1:0] dist_now;

    // Modular distances from the last sample; wraparound handled by the subtraction.
    always_comb begin
        dist_cmp = cmp_val - prev_val;
        dist_now = now_val - prev_val;
        hit      = (dist_cmp != '0) && (dist_cmp <= dist_now);
    end

endmodule

// File: rtl/cb_flags.sv
module cb_flags #(
    parameter int NUM_CH = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] set_vec,
    input  logic [NUM_CH-1:0] clr_vec,
    input  logic [NUM_CH-1:0] en_vec,
    output logic [NUM_CH-1:0] flag_vec,
    output logic              irq
);
    // A set in the same cycle as a clear wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_vec <= '0;
        end else begin
            flag_vec <= (flag_vec & ~clr_vec) | set_vec;
        end
    end

    always_comb begin
        irq = |(flag_vec & en_vec);
    end

endmodule

// File: rtl/compare_bank.sv
module compare_bank
    import cb_pkg::*;
#(
    parameter int NUM_CH = 5,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic              cnt_adv,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [NUM_CH-1:0] flag_o,
    output logic              irq
);
    localparam int BYTES    = CNT_W / DATA_W;
    localparam int CMP_SPAN = NUM_CH * BYTES;
    localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(CMP_SPAN);
    localparam logic [ADDR_W-1:0] FLAG_A = ADDR_W'(CMP_SPAN + 1);

    cb_state_e             state_q, state_d;
    cb_wr_kind_t           wr_kind;
    logic [NUM_CH-1:0]     ch_bits;
    logic [NUM_CH*CNT_W-1:0] cmp_flat;
    logic [NUM_CH-1:0]     en_vec;
    logic [NUM_CH-1:0]     hit_vec;
    logic [NUM_CH-1:0]     set_vec;
    logic [NUM_CH-1:0]     clr_vec;
    logic [NUM_CH-1:0]     flag_vec;
    logic [CNT_W-1:0]      prev_q;
    logic                  rebase;
    logic                  detect_en;

    // Write decode.
    always_comb begin
        wr_kind.cmp  = wr_en && (addr < MASK_A);
        wr_kind.mask = wr_en && (addr == MASK_A);
        wr_kind.flag = wr_en && (addr == FLAG_A);
        rebase       = wr_kind.cmp || wr_kind.mask;
    end

    // Channel k lives at byte bit DATA_W-1-k.
    for (genvar k = 0; k < NUM_CH; k++) begin : g_bits
        assign ch_bits[k]           = wdata[DATA_W-1-k];
        assign clr_vec[k]           = wr_kind.flag && wdata[DATA_W-1-k];
        assign flag_o[NUM_CH-1-k]   = flag_vec[k];
    end

    cb_regfile #(
        .NUM_CH(NUM_CH), .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_kind (wr_kind),
        .addr    (addr),
        .wdata   (wdata),
        .ch_bits (ch_bits),
        .cmp_flat(cmp_flat),
        .en_vec  (en_vec)
    );

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_WAIT_ENABLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: ENABLE_ON and ENABLE_OFF transitions.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT_ENABLE: if (wr_kind.mask && (|ch_bits))  state_d = ST_TRACK;
            ST_TRACK:       if (wr_kind.mask && !(|ch_bits)) state_d = ST_WAIT_ENABLE;
            default:        state_d = ST_WAIT_ENABLE;
        endcase
    end

    // State outputs.
    always_comb begin
        detect_en = 1'b0;
        unique case (state_q)
            ST_WAIT_ENABLE: detect_en = 1'b0;
            ST_TRACK:       detect_en = cnt_adv && !rebase;
            default:        detect_en = 1'b0;
        endcase
    end

    // Window start: last advanced value, or the value at a rebase write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else if (rebase || cnt_adv) begin
            prev_q <= cnt_val;
        end
    end

    for (genvar k = 0; k < NUM_CH; k++) begin : g_win
        cb_window #(.CNT_W(CNT_W)) u_win (
            .prev_val(prev_q),
            .now_val (cnt_val),
            .cmp_val (cmp_flat[k*CNT_W +: CNT_W]),
            .hit     (hit_vec[k])
        );
    end

    assign set_vec = hit_vec & {NUM_CH{detect_en}};

    cb_flags #(.NUM_CH(NUM_CH)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .en_vec  (en_vec),
        .flag_vec(flag_vec),
        .irq     (irq)
    );

    // Combinational read port.
    always_comb begin
        rdata = '0;
        for (int k = 0; k < NUM_CH; k++) begin
            for (int b = 0; b < BYTES; b++) begin
                if (addr == ADDR_W'(k*BYTES + b)) begin
                    rdata = cmp_flat[k*CNT_W + (BYTES-1-b)*DATA_W +: DATA_W];
                end
            end
        end
        if (addr == MASK_A) begin
            for (int k = 0; k < NUM_CH; k++) rdata[DATA_W-1-k] = en_vec[k];
        end
        if (addr == FLAG_A) begin
            for (int k = 0; k < NUM_CH; k++) rdata[DATA_W-1-k] = flag_vec[k];
        end
    end

endmodule

// File: rtl/compare_bank_checker.sv
module compare_bank_checker
    import cb_pkg::*;
#(
    parameter int NUM_CH = 5,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cnt_adv,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input cb_state_e         state_q,
    input logic [NUM_CH-1:0] flag_vec,
    input logic [NUM_CH-1:0] set_vec,
    input logic [NUM_CH-1:0] clr_vec,
    input logic              irq
);
    localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(NUM_CH * (CNT_W / DATA_W));

    // R1: leaving reset, nothing is flagged and no request is raised.
    assert_reset_clear_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (flag_vec == '0) && !irq && (state_q == ST_WAIT_ENABLE));

    // R4: a new flag only follows an advance strobe.
    assert_set_needs_adv_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_vec & ~$past(flag_vec)) != '0) |-> $past(cnt_adv));

    // R7: a clear without a coinciding match empties the bit.
    assert_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_vec != '0) |=> ((flag_vec & $past(clr_vec & ~set_vec)) == '0));

    // R8: nothing sets while scheduling is inactive.
    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_ENABLE) |=> ((flag_vec & ~$past(flag_vec)) == '0));

    // R9: a compare or mask write detects nothing in its own cycle.
    assert_rebase_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr <= MASK_A)) |=> ((flag_vec & ~$past(flag_vec)) == '0));

    // R10: a request always has a pending flag behind it.
    assert_irq_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flag_vec != '0));

endmodule

bind compare_bank compare_bank_checker #(
    .NUM_CH(NUM_CH), .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnt_adv (cnt_adv),
    .wr_en   (wr_en),
    .addr    (addr),
    .state_q (state_q),
    .flag_vec(flag_vec),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .irq     (irq)
);

// File: tb/compare_bank_test.sv
module compare_bank_test;
    localparam int CLK_PERIOD = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] b_cnt = '0;
    logic        b_adv = 1'b0;
    logic        b_wr = 1'b0;
    logic [3:0]  b_addr = '0;
    logic [7:0]  b_wdata = '0;
    logic [7:0]  rdata;
    logic [4:0]  flag_o;
    logic        irq;

    int    n_checks = 0;
    int    n_fail   = 0;
    string cur_req  = "R1";

    // Reference model state.
    int m_cmp [5];
    bit m_en  [5];
    bit m_flg [5];
    bit m_trk;
    int m_prev;

    always #(CLK_PERIOD/2) clk = ~clk;

    compare_bank uut (
        .clk(clk), .rst_n(rst_n), .cnt_val(b_cnt), .cnt_adv(b_adv),
        .wr_en(b_wr), .addr(b_addr), .wdata(b_wdata),
        .rdata(rdata), .flag_o(flag_o), .irq(irq)
    );

    function automatic int flag_byte();
        int v = 0;
        for (int k = 0; k < 5; k++) if (m_flg[k]) v += (128 >> k);
        return v;
    endfunction

    function automatic int mask_byte();
        int v = 0;
        for (int k = 0; k < 5; k++) if (m_en[k]) v += (128 >> k);
        return v;
    endfunction

    function automatic bit model_irq();
        bit r = 0;
        for (int k = 0; k < 5; k++) if (m_flg[k] && m_en[k]) r = 1;
        return r;
    endfunction

    task automatic model_step();
        bit hits [5];
        bit rb;
        int span;
        if (!rst_n) begin
            for (int k = 0; k < 5; k++) begin
                m_cmp[k] = 65535; m_en[k] = 0; m_flg[k] = 0;
            end
            m_trk = 0; m_prev = 0;
            return;
        end
        rb = b_wr && (b_addr <= 4'd10);
        span = (int'(b_cnt) - m_prev + 65536) % 65536;
        for (int k = 0; k < 5; k++) begin
            int gap = (m_cmp[k] - m_prev + 65536) % 65536;
            hits[k] = m_trk && b_adv && !rb && gap > 0 && gap <= span;
        end
        if (b_wr) begin
            if (b_addr < 4'd10) begin
                int ch = b_addr / 2;
                if (b_addr % 2 == 0) m_cmp[ch] = (m_cmp[ch] % 256) + b_wdata * 256;
                else                 m_cmp[ch] = (m_cmp[ch] / 256) * 256 + b_wdata;
            end else if (b_addr == 4'd10) begin
                m_trk = 0;
                for (int k = 0; k < 5; k++) begin
                    m_en[k] = b_wdata[7-k];
                    if (m_en[k]) m_trk = 1;
                end
            end else if (b_addr == 4'd11) begin
                for (int k = 0; k < 5; k++) if (b_wdata[7-k]) m_flg[k] = 0;
            end
        end
        for (int k = 0; k < 5; k++) if (hits[k]) m_flg[k] = 1;
        if (rb || b_adv) m_prev = b_cnt;
    endtask

    task automatic check(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One clock: model follows the edge, outputs compared mid-cycle.
    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        check(cur_req, "flag_o", int'(flag_o), flag_byte() / 8);
        check(cur_req, "irq", int'(irq), int'(model_irq()));
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        b_wr = 1; b_addr = a; b_wdata = d;
        cyc();
        b_wr = 0;
    endtask

    task automatic adv(input logic [15:0] v);
        b_cnt = v; b_adv = 1;
        cyc();
        b_adv = 0;
    endtask

    task automatic rd(input logic [3:0] a, input int exp, input string req);
        b_addr = a;
        #2;
        check(req, $sformatf("rdata@%0d", a), int'(rdata), exp);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_checks - n_fail + 1, n_checks + 1);
        $finish;
    end

    initial begin
        // R1 reset state
        cur_req = "R1";
        repeat (3) cyc();
        rst_n = 1;
        cyc();
        for (int a = 0; a < 10; a++) rd(4'(a), 8'hFF, "R1");
        rd(4'd10, 0, "R1");
        rd(4'd11, 0, "R1");
        check("R1", "irq", int'(irq), 0);

        // R2 / R3 register map
        cur_req = "R2";
        b_cnt = 16'h0100;
        wr(4'd0, 8'h01); wr(4'd1, 8'h05);
        wr(4'd2, 8'h02); wr(4'd3, 8'h00);
        wr(4'd4, 8'h03); wr(4'd5, 8'h00);
        wr(4'd6, 8'h04); wr(4'd7, 8'h00);
        wr(4'd8, 8'h05); wr(4'd9, 8'h00);
        rd(4'd0, 8'h01, "R2"); rd(4'd1, 8'h05, "R2");
        rd(4'd6, 8'h04, "R2"); rd(4'd9, 8'h00, "R2");
        wr(4'd12, 8'h55);
        rd(4'd12, 0, "R2");
        cur_req = "R3";
        wr(4'd10, 8'hFF);
        rd(4'd10, 8'hF8, "R3");

        // R4 span detection, exact landing
        cur_req = "R4";
        adv(16'h0104);
        check("R4", "no early flag", int'(flag_o), 0);
        adv(16'h0105);
        check("R4", "ch1 on landing", int'(flag_o), 5'b10000);
        adv(16'h0250);
        rd(4'd11, 8'hC0, "R4");

        // R7 write-one-to-clear, set wins
        cur_req = "R7";
        wr(4'd11, 8'h40);
        rd(4'd11, 8'h80, "R7");
        wr(4'd11, 8'h00);
        rd(4'd11, 8'h80, "R7");
        b_cnt = 16'h0300; b_adv = 1; b_wr = 1; b_addr = 4'd11; b_wdata = 8'hA7;
        cyc();
        b_adv = 0; b_wr = 0;
        rd(4'd11, 8'h20, "R7");

        // R6 once per pass
        cur_req = "R6";
        wr(4'd11, 8'hF8);
        adv(16'h0300);
        adv(16'h0301);
        rd(4'd11, 0, "R6");

        // R5 wraparound
        cur_req = "R5";
        wr(4'd6, 8'h00); wr(4'd7, 8'h02);
        adv(16'hFFF0);
        rd(4'd11, 8'h08, "R5");
        wr(4'd11, 8'hF8);
        adv(16'h0005);
        rd(4'd11, 8'h10, "R5");
        wr(4'd11, 8'hF8);

        // R9 rebase on write
        cur_req = "R9";
        b_cnt = 16'h0005; b_adv = 1;
        wr(4'd1, 8'h06);
        b_adv = 0;
        adv(16'h0006);
        rd(4'd11, 0, "R9");
        b_cnt = 16'h0400; b_adv = 1;
        wr(4'd1, 8'h05);
        b_adv = 0;
        rd(4'd11, 0, "R9");

        // R8 inactive when no enable
        cur_req = "R8";
        wr(4'd10, 8'h00);
        adv(16'h1000);
        adv(16'h0450);
        adv(16'h1000);
        rd(4'd11, 0, "R8");

        // R10 interrupt gating
        cur_req = "R10";
        wr(4'd10, 8'h08);
        adv(16'h0250);
        rd(4'd11, 8'hD0, "R10");
        check("R10", "irq gated", int'(irq), 0);
        adv(16'h0600);
        rd(4'd11, 8'hF8, "R10");
        check("R10", "irq raised", int'(irq), 1);
        wr(4'd11, 8'h08);
        check("R10", "irq dropped", int'(irq), 0);

        // R11 strobe-only sampling
        cur_req = "R11";
        wr(4'd11, 8'hF8);
        b_cnt = 16'h0003;
        repeat (3) cyc();
        rd(4'd11, 0, "R11");
        adv(16'h0003);
        rd(4'd11, 8'h10, "R11");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule